// File: doc/BRIEF.md
# Banked Memory Decoder with Switchable Register Window

This block sits between a small soft processor and its data storage. The processor has an 8-bit port address. A bank register supplies the upper address bits that reach a larger block RAM, so each processor access lands in one bank of that RAM. The highest eight port addresses can also serve as a register window, which is routed to a register-side interface instead of to RAM. A sticky enable flag turns the window on and off.

The enable flag changes as a side effect of normal accesses. An access to the address just below the window turns the window off. After that, software can walk the whole selected bank, including its top eight bytes. An access to any lower address turns the window back on. While the window is on, every register write is also copied into a fixed shadow bank of RAM. Software can read that copy later to recover bits that are otherwise write-only.

Bit 0 of the topmost register's read value is a toggle that inverts after every read. Software reads that address twice in a row to learn whether the window is on: the two values differ only when it is. The top bank of RAM is shared with another agent through the RAM's second port. That port is outside this block.

Top module: `bank_window_ctrl`

## Requirements
- R1: An ordinary RAM access drives `ram_addr` as {bank, cpu_addr}, where the bank comes from `bank_q`. `bank_q` loads `bank_d` on a clock edge with `bank_we` high.
- R2: While the window is enabled, a read of 0xF8..0xFF pulses `reg_rd` with `reg_idx` = cpu_addr[2:0] and makes no RAM access (`ram_en` low). The register value appears on `cpu_rdata` in the following cycle.
- R3: While the window is enabled, a write of 0xF8..0xFF pulses `reg_wr` with `reg_idx` = cpu_addr[2:0] and the write data. The same cycle writes that byte to RAM at {3'd6, cpu_addr} (0x6F8..0x6FF), whatever the bank register holds.
- R4: A read or write of 0xF7 clears the window enable from the next access on. The 0xF7 access itself is an ordinary RAM access to {bank, 0xF7}.
- R5: A read or write of any address 0x00..0xF6 sets the window enable from the next access on.
- R6: Accesses to 0xF8..0xFF leave the window enable unchanged.
- R7: While the window is disabled, 0xF8..0xFF are ordinary RAM addresses in the selected bank. `reg_rd` and `reg_wr` stay low.
- R8: Bit 0 of a window read of 0xFF is replaced by a toggle bit. Bits 7..1 come from the register. The toggle inverts after every read cycle of any address. Two back-to-back window reads of 0xFF therefore differ in bit 0, and two RAM reads of 0xFF do not.
- R9: After reset the window is enabled (`win_active` = 1), `bank_q` = 0 and the toggle bit is 0.
- R10: `cpu_rdata` shows the read result in the cycle after `cpu_rd`, taken from the register path or from `ram_rdata` according to where that read was routed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 8 | Processor port address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rd | input | 1 | Processor read strobe, one cycle |
| cpu_wr | input | 1 | Processor write strobe, one cycle |
| cpu_rdata | output | 8 | Read data, valid the cycle after `cpu_rd` |
| bank_we | input | 1 | Load strobe for the bank register |
| bank_d | input | 3 | New bank value |
| bank_q | output | 3 | Current bank value |
| win_active | output | 1 | Register window enable flag |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_idx | output | 3 | Register index within the window |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read value for `reg_idx`, sampled with `reg_rd` |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 11 | RAM address {bank, offset} |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after the read |

## Verification
The bench uses the default parameters: an 8-bit port address, three bank bits, an eight-entry window and shadow bank 6. These values put the enable-clearing address at 0xF7 and the shadow copies at 0x6F8..0x6FF of a 2 KiB RAM, which is small enough for the bench to model in full. Using bank 2 for normal traffic keeps the shadow bank distinct from the selected bank. Reading the shadow bank back through bank 6 with the window off shows the copy through the ports. Because the bench tracks the read count, the toggle bit has a known value at every read of 0xFF.

// File: rtl/bw_pkg.sv
// Package bw_pkg
// Shared types for the banked window decoder.
// Assumes: nothing beyond the standard language.
package bw_pkg;
    // Address class seen by the window logic
    typedef enum logic [1:0] {
        CLS_LOW = 2'd0,   // below the clear address: sets the enable
        CLS_OFF = 2'd1,   // the clear address just under the window
        CLS_WIN = 2'd2    // inside the register window
    } addr_cls_t;
endpackage

// File: rtl/bw_addr_class.sv
// Module bw_addr_class
// Sorts a processor port address into one of three classes: window,
// enable-clear, or low. Purely combinational.
// Assumes: NREG is a power of two and smaller than the port space.
module bw_addr_class
    import bw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NREG   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output addr_cls_t         cls
);
    localparam int WIN_BASE = (1 << ADDR_W) - NREG;
    localparam int OFF_ADDR = WIN_BASE - 1;

    // Compare the address against the window base and the clear address
    always_comb begin
        if (int'(addr) >= WIN_BASE)      cls = CLS_WIN;
        else if (int'(addr) == OFF_ADDR) cls = CLS_OFF;
        else                             cls = CLS_LOW;
    end
endmodule

// File: rtl/bw_win_state.sv
// Module bw_win_state
// Holds the bank register, the sticky window enable and the read toggle.
// Assumes: acc is high for exactly the cycles in which a strobe is high.
module bw_win_state
    import bw_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              rd,
    input  addr_cls_t         cls,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_d,
    output logic [BANK_W-1:0] bank_q,
    output logic              en_q,
    output logic              tog_q
);
    // Load the bank register on request
    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= '0;
        else if (bank_we) bank_q <= bank_d;
    end

    // Enable flag changes as a side effect of low and clear-address accesses
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else if (acc) begin
            case (cls)
                CLS_LOW: en_q <= 1'b1;
                CLS_OFF: en_q <= 1'b0;
                default: en_q <= en_q;
            endcase
        end
    end

    // Toggle bit inverts after every read cycle
    always_ff @(posedge clk) begin
        if (!rst_n)  tog_q <= 1'b0;
        else if (rd) tog_q <= ~tog_q;
    end

    // R4
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cls == CLS_OFF) |=> !en_q);
    // R5
    low_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cls == CLS_LOW) |=> en_q);
    // R6
    win_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cls == CLS_WIN) |=> $stable(en_q));
    // R8
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (tog_q != $past(tog_q)));
endmodule

// File: rtl/bw_route.sv
// Module bw_route
// Steers an access to RAM or the register port, shadows window writes into
// a fixed bank and returns read data one cycle later.
// Assumes: RAM read data appears one cycle after a read with ram_en high;
// reg_rdata is valid in the cycle reg_rd is high.
module bw_route
    import bw_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                BANK_W      = 3,
    parameter int                DATA_W      = 8,
    parameter int                NREG        = 8,
    parameter bit                SHADOW_EN   = 1'b1,
    parameter logic [BANK_W-1:0] SHADOW_BANK = 3'd6,
    localparam int               IDX_W       = $clog2(NREG),
    localparam int               RAM_AW      = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    input  logic              wr,
    input  addr_cls_t         cls,
    input  logic              en,
    input  logic              tog,
    input  logic [BANK_W-1:0] bank,
    output logic [DATA_W-1:0] rdata,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    logic              win_hit;
    logic              shadow_wr;
    logic              sel_reg_q;
    logic [DATA_W-1:0] reg_q;

    // Window hit only while enabled
    assign win_hit   = en && (cls == CLS_WIN);
    assign reg_rd    = win_hit && rd;
    assign reg_wr    = win_hit && wr;
    assign reg_idx   = addr[IDX_W-1:0];
    assign reg_wdata = wdata;

    // Shadow variant chosen by parameter
    generate
        if (SHADOW_EN) begin : g_shadow
            assign shadow_wr = reg_wr;
        end else begin : g_no_shadow
            assign shadow_wr = 1'b0;
        end
    endgenerate

    // RAM port: window reads skip RAM, window writes go to the shadow bank
    always_comb begin
        ram_en    = (rd || wr) && !(win_hit && (rd || !SHADOW_EN));
        ram_we    = wr && ram_en;
        ram_addr  = shadow_wr ? {SHADOW_BANK, addr} : {bank, addr};
        ram_wdata = wdata;
    end

    // Capture the register value and the read source on each read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_reg_q <= 1'b0;
            reg_q     <= '0;
        end else if (rd) begin
            sel_reg_q <= win_hit;
            if (win_hit) begin
                if (int'(reg_idx) == NREG - 1) reg_q <= {reg_rdata[DATA_W-1:1], tog};
                else                           reg_q <= reg_rdata;
            end
        end
    end

    // Return data from whichever path served the last read
    assign rdata = sel_reg_q ? reg_q : ram_rdata;

    // R2
    win_read_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> !ram_en);
    // R3
    shadow_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && SHADOW_EN) |-> (ram_we && ram_addr[RAM_AW-1:ADDR_W] == SHADOW_BANK));
    // R7
    disabled_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!reg_rd && !reg_wr));
    // R2
    reg_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_rd, reg_wr}));
endmodule

// File: rtl/bank_window_ctrl.sv
// Module bank_window_ctrl
// Top: banked RAM decoder with a sticky register window over the top
// NREG port addresses and shadowing of register writes into RAM.
// Assumes: cpu_rd and cpu_wr are never high together.
module bank_window_ctrl
    import bw_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter int                BANK_W      = 3,
    parameter int                DATA_W      = 8,
    parameter int                NREG        = 8,
    parameter bit                SHADOW_EN   = 1'b1,
    parameter logic [BANK_W-1:0] SHADOW_BANK = 3'd6,
    localparam int               IDX_W       = $clog2(NREG),
    localparam int               RAM_AW      = ADDR_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_d,
    output logic [BANK_W-1:0] bank_q,
    output logic              win_active,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);
    addr_cls_t cls;
    logic      tog;

    bw_addr_class #(.ADDR_W(ADDR_W), .NREG(NREG)) u_class (
        .addr (cpu_addr),
        .cls  (cls)
    );

    bw_win_state #(.BANK_W(BANK_W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (cpu_rd || cpu_wr),
        .rd      (cpu_rd),
        .cls     (cls),
        .bank_we (bank_we),
        .bank_d  (bank_d),
        .bank_q  (bank_q),
        .en_q    (win_active),
        .tog_q   (tog)
    );

    bw_route #(
        .ADDR_W(ADDR_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .NREG(NREG),
        .SHADOW_EN(SHADOW_EN), .SHADOW_BANK(SHADOW_BANK)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (cpu_addr),
        .wdata     (cpu_wdata),
        .rd        (cpu_rd),
        .wr        (cpu_wr),
        .cls       (cls),
        .en        (win_active),
        .tog       (tog),
        .bank      (bank_q),
        .rdata     (cpu_rdata),
        .reg_rd    (reg_rd),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ram_en    (ram_en),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );

    // R1
    plain_bank_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && cls == CLS_LOW) |-> (ram_addr[RAM_AW-1:ADDR_W] == bank_q));
endmodule

// File: tb/tb_bank_window_ctrl.sv
// Bench for bank_window_ctrl: a RAM and register-file model, a vector
// table walked by one loop, then directed reset and corner-case tests.
module tb_bank_window_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic        bank_we = 1'b0;
    logic [2:0]  bank_d = '0, bank_q;
    logic        win_active, reg_rd, reg_wr, ram_en, ram_we;
    logic [2:0]  reg_idx;
    logic [7:0]  reg_wdata, reg_rdata, ram_wdata, ram_rdata;
    logic [10:0] ram_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    bank_window_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .bank_we(bank_we), .bank_d(bank_d), .bank_q(bank_q),
        .win_active(win_active), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // RAM model: byte at a = a[7:0] ^ (a[10:8] << 5) after reset
    logic [7:0] mem [0:2047];
    logic [7:0] ram_q;
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= 8'(i) ^ 8'((i >> 8) << 5);
            ram_q <= '0;
        end else if (ram_en) begin
            if (ram_we) mem[ram_addr] <= ram_wdata;
            else        ram_q <= mem[ram_addr];
        end
    end
    assign ram_rdata = ram_q;

    // Register model: register i holds 0x50 + i after reset
    logic [7:0] breg [0:7];
    always @(posedge clk) begin
        if (!rst_n) for (int i = 0; i < 8; i++) breg[i] <= 8'h50 + 8'(i);
        else if (reg_wr) breg[reg_idx] <= reg_wdata;
    end
    assign reg_rdata = breg[reg_idx];

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One access: strobe for one cycle, return at the negedge after the edge
    task automatic op(input logic wr, input logic [7:0] a, input logic [7:0] d);
        cpu_addr = a; cpu_wdata = d; cpu_wr = wr; cpu_rd = !wr;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic load_bank(input logic [2:0] b);
        bank_d = b; bank_we = 1'b1;
        @(negedge clk);
        bank_we = 1'b0;
    endtask

    // {wr, addr, wdata, expected rdata, expected enable, requirement}, bank 2
    localparam logic [29:0] VEC [0:18] = '{
        {1'b0, 8'hF9, 8'h00, 8'h51, 1'b1, 4'd2},   // R2 window read
        {1'b1, 8'hFA, 8'h3C, 8'h00, 1'b1, 4'd6},   // R3 window write, R6
        {1'b0, 8'hFA, 8'h00, 8'h3C, 1'b1, 4'd3},   // R3 register updated
        {1'b0, 8'hFF, 8'h00, 8'h56, 1'b1, 4'd8},   // R8 toggle 0
        {1'b0, 8'hFF, 8'h00, 8'h57, 1'b1, 4'd8},   // R8 toggle 1
        {1'b0, 8'hF7, 8'h00, 8'hB7, 1'b0, 4'd4},   // R4 clear, own access RAM
        {1'b0, 8'hFA, 8'h00, 8'hBA, 1'b0, 4'd7},   // R7 bank-2 RAM
        {1'b1, 8'hFB, 8'h99, 8'h00, 1'b0, 4'd7},   // R7 RAM write
        {1'b0, 8'hFB, 8'h00, 8'h99, 1'b0, 4'd7},   // R7 RAM readback
        {1'b0, 8'hFF, 8'h00, 8'hBF, 1'b0, 4'd8},   // R8 no toggle from RAM
        {1'b0, 8'hFF, 8'h00, 8'hBF, 1'b0, 4'd8},   // R8 same value again
        {1'b1, 8'h10, 8'h22, 8'h00, 1'b1, 4'd5},   // R5 write sets enable
        {1'b0, 8'hFB, 8'h00, 8'h53, 1'b1, 4'd7},   // R7 register untouched
        {1'b0, 8'h10, 8'h00, 8'h22, 1'b1, 4'd1},   // R1 bank-2 RAM
        {1'b1, 8'hF7, 8'h77, 8'h00, 1'b0, 4'd4},   // R4 write clears
        {1'b0, 8'hF7, 8'h00, 8'h77, 1'b0, 4'd4},   // R4 RAM at {2,F7}
        {1'b1, 8'hF6, 8'h11, 8'h00, 1'b1, 4'd5},   // R5 0xF6 sets
        {1'b0, 8'hFF, 8'h00, 8'h56, 1'b1, 4'd8},   // R8 toggle after 14 reads
        {1'b0, 8'h20, 8'h00, 8'h60, 1'b1, 4'd10}   // R10 RAM read path
    };

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check(9, "enable after reset", {7'b0, win_active}, 8'h01);
        check(9, "bank after reset", {5'b0, bank_q}, 8'h00);
        // R2 window read drives register port, not RAM
        cpu_addr = 8'hFF; cpu_rd = 1'b1;
        #1;
        check(2, "ram_en on window read", {7'b0, ram_en}, 8'h00);
        check(2, "reg_rd/reg_idx", {reg_rd, 4'b0, reg_idx}, 8'h87);
        @(negedge clk); cpu_rd = 1'b0;
        check(9, "first toggle value", cpu_rdata, 8'h56);
        op(1'b0, 8'hFF, 8'h00);
        check(8, "second toggle value", cpu_rdata, 8'h57);
        load_bank(3'd2);
        check(1, "bank load", {5'b0, bank_q}, 8'h02);

        for (int k = 0; k < 19; k++) begin
            logic [29:0] v;
            v = VEC[k];
            op(v[29], v[28:21], v[20:13]);
            if (!v[29]) check(int'(v[3:0]), $sformatf("step %0d data", k), cpu_rdata, v[12:5]);
            check(int'(v[3:0]), $sformatf("step %0d enable", k), {7'b0, win_active}, {7'b0, v[4]});
        end

        // R3 shadow copy visible in bank 6 once the window is off
        load_bank(3'd6);
        op(1'b0, 8'hF7, 8'h00);
        check(4, "bank-6 F7", cpu_rdata, 8'h37);
        op(1'b0, 8'hFA, 8'h00);
        check(3, "shadow of 0xFA", cpu_rdata, 8'h3C);
        // R3 shadow address independent of the bank: write with bank 1
        load_bank(3'd1);
        op(1'b1, 8'h00, 8'h00);
        cpu_addr = 8'hFC; cpu_wdata = 8'hA5; cpu_wr = 1'b1;
        #1;
        check(3, "shadow addr high", {5'b0, ram_addr[10:8]}, 8'h06);
        check(3, "shadow ram_we/reg_wr", {6'b0, ram_we, reg_wr}, 8'h03);
        @(negedge clk); cpu_wr = 1'b0;
        op(1'b0, 8'hFC, 8'h00);
        check(3, "register 4 written", cpu_rdata, 8'hA5);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule